// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the power-down control of a small microcontroller and picks the low-power state to enter when the processor issues a sleep request. It has two running modes. Active runs from the main clock. Subactive runs from the slow sub clock. The same standby bit sends a sleep request to a different target state in each running mode. A wake event brings the block back to a running mode. When the main oscillator has been stopped, a settling counter keeps the main clock enable low until the oscillator has had time to restart.

Software reaches two byte-wide control registers through a simple synchronous write port and a combinational read port. The sleep request, wake event and watch-select inputs are plain control strobes and levels. The block has no stream interfaces, so it has no valid/ready handshake and never applies back-pressure. A bus write always completes in the cycle it is presented.

The outputs are the current mode as a 3-bit code, plus one enable for the main clock and one for the sub clock.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the mode is active (code 0), register 1 reads 0x07, register 2 reads 0xF0, and both clock enables are high.
- R2: Register 1 is at address 0xFFF0 and has these read/write fields:
  - bit 7: standby select.
  - bits 6:4: settle select.
  - bit 3: low-speed return.
  - bits 1:0: divider select.

  Bit 2 always reads 1 and ignores writes. A write to any address other than the two register addresses changes neither register.
- R3: Register 2 is at address 0xFFF1. Bits 3:0 are read/write. Bits 7:4 always read 1.
- R4: In active mode with standby select at 0, a sleep request enters sleep mode (code 1) at the next clock edge.
- R5: In subactive mode with standby select at 0, a sleep request enters subsleep mode (code 5).
- R6: In active mode with standby select at 1, a sleep request enters one of two states, chosen by `watch_sel`:
  - `watch_sel` high: watch mode (code 3).
  - `watch_sel` low: standby mode (code 2).
- R7: In subactive mode (code 4) with standby select at 1, a sleep request always enters watch mode, whatever the level of `watch_sel`.
- R8: A wake event returns sleep mode to active mode and subsleep mode to subactive mode. A wake event in active or subactive mode has no effect.
- R9: A wake event in watch mode leads to one of two modes, chosen by the low-speed return bit:
  - bit at 1: subactive mode.
  - bit at 0: active mode.
- R10: The settling hold applies on a wake from standby mode, and on a wake from watch mode into active mode.
  - The mode reads active from the next edge.
  - The main clock enable stays low for 2^(8+S) cycles, where S is the settle select field.
  - Sleep requests are ignored during that hold.
- R11: Clock enables by mode:
  - The main clock enable is high only in active and sleep modes, and only outside a settling hold.
  - The sub clock enable is high in every mode except standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the control registers |
| bus_addr | input | 16 | Register address for write and read |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Combinational read data for `bus_addr` (0 for unmapped addresses) |
| sleep_req | input | 1 | Sleep request strobe from the processor |
| wake_evt | input | 1 | Wake event |
| watch_sel | input | 1 | Selects watch (1) over standby (0) when sleeping from active mode |
| mode_o | output | 3 | Current mode code |
| main_clk_en | output | 1 | Main clock enable |
| sub_clk_en | output | 1 | Sub clock enable |

## Verification
The assertions assume the following about the inputs:
- Every input is synchronous to `clk` and holds a known value once reset is released.
- `watch_sel` and the control register fields are steady over the edge where a sleep request is taken.
- The address is driven whenever read data is checked.

The stimulus keeps within this by changing every input one nanosecond after a rising edge. It raises sleep and wake only as single-cycle pulses, one at a time, and finishes each register write before the strobe that depends on it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_ACTIVE   = 3'd0,
    MODE_SLEEP    = 3'd1,
    MODE_STANDBY  = 3'd2,
    MODE_WATCH    = 3'd3,
    MODE_SUBACT   = 3'd4,
    MODE_SUBSLEEP = 3'd5
  } lpm_mode_e;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned BASE_EXP = 8;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter logic [AW-1:0] ADDR_C1 = 16'hFFF0,
  parameter logic [AW-1:0] ADDR_C2 = 16'hFFF1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             stby,
  output logic [SEL_W-1:0] settle_sel,
  output logic             low_spd
);

  logic [1:0] div_sel;
  logic [3:0] c2_lo;
  logic       hit_c1;
  logic       hit_c2;

  assign hit_c1 = (addr == ADDR_C1);
  assign hit_c2 = (addr == ADDR_C2);

  // control register 1 fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby       <= 1'b0;
      settle_sel <= '0;
      low_spd    <= 1'b0;
      div_sel    <= 2'b11;
    end else if (wr_en && hit_c1) begin
      stby       <= wr_data[7];
      settle_sel <= wr_data[6:4];
      low_spd    <= wr_data[3];
      div_sel    <= wr_data[1:0];
    end
  end

  // control register 2 storage nibble
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      c2_lo <= 4'h0;
    else if (wr_en && hit_c2)
      c2_lo <= wr_data[3:0];
  end

  always_comb begin
    rd_data = 8'h00;
    if (hit_c1)
      rd_data = {stby, settle_sel, low_spd, 1'b1, div_sel};
    else if (hit_c2)
      rd_data = {4'hF, c2_lo};
  end

endmodule

// File: rtl/lpm_settle.sv
module lpm_settle
  import lpm_pkg::*;
#(
  parameter int unsigned EXP0 = BASE_EXP,
  parameter int unsigned SW   = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] sel,
  output logic          busy
);

  localparam int unsigned CNT_W = EXP0 + (1 << SW);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= CNT_W'(1) << (EXP0 + int'(sel));
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      wake_evt,
  input  logic      watch_sel,
  input  logic      stby,
  input  logic      low_spd,
  input  logic      settle_busy,
  output lpm_mode_e mode,
  output logic      settle_start
);

  lpm_mode_e nxt;

  always_comb begin
    nxt          = mode;
    settle_start = 1'b0;
    unique case (mode)
      MODE_ACTIVE: begin
        if (sleep_req && !settle_busy) begin
          if (!stby)          nxt = MODE_SLEEP;
          else if (watch_sel) nxt = MODE_WATCH;
          else                nxt = MODE_STANDBY;
        end
      end
      MODE_SUBACT: begin
        if (sleep_req)
          nxt = stby ? MODE_WATCH : MODE_SUBSLEEP;
      end
      MODE_SLEEP: begin
        if (wake_evt) nxt = MODE_ACTIVE;
      end
      MODE_SUBSLEEP: begin
        if (wake_evt) nxt = MODE_SUBACT;
      end
      MODE_STANDBY: begin
        if (wake_evt) begin
          nxt          = MODE_ACTIVE;
          settle_start = 1'b1;
        end
      end
      MODE_WATCH: begin
        if (wake_evt) begin
          if (low_spd) begin
            nxt = MODE_SUBACT;
          end else begin
            nxt          = MODE_ACTIVE;
            settle_start = 1'b1;
          end
        end
      end
      default: nxt = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_ACTIVE;
    else        mode <= nxt;
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter logic [AW-1:0] ADDR_C1 = 16'hFFF0,
  parameter logic [AW-1:0] ADDR_C2 = 16'hFFF1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wr_data,
  output logic [7:0]    bus_rd_data,
  input  logic          sleep_req,
  input  logic          wake_evt,
  input  logic          watch_sel,
  output logic [2:0]    mode_o,
  output logic          main_clk_en,
  output logic          sub_clk_en
);

  logic             stby_w;
  logic             low_spd_w;
  logic [SEL_W-1:0] settle_sel_w;
  logic             settle_start_w;
  logic             settle_busy_w;
  lpm_mode_e        mode_w;

  lpm_regs #(.AW(AW), .ADDR_C1(ADDR_C1), .ADDR_C2(ADDR_C2)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr_en),
    .addr       (bus_addr),
    .wr_data    (bus_wr_data),
    .rd_data    (bus_rd_data),
    .stby       (stby_w),
    .settle_sel (settle_sel_w),
    .low_spd    (low_spd_w)
  );

  lpm_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .wake_evt     (wake_evt),
    .watch_sel    (watch_sel),
    .stby         (stby_w),
    .low_spd      (low_spd_w),
    .settle_busy  (settle_busy_w),
    .mode         (mode_w),
    .settle_start (settle_start_w)
  );

  lpm_settle #(.EXP0(BASE_EXP), .SW(SEL_W)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start_w),
    .sel   (settle_sel_w),
    .busy  (settle_busy_w)
  );

  assign mode_o      = mode_w;
  assign main_clk_en = ((mode_w == MODE_ACTIVE) || (mode_w == MODE_SLEEP)) && !settle_busy_w;
  assign sub_clk_en  = (mode_w != MODE_STANDBY);

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk
  import lpm_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_req,
  input logic        wake_evt,
  input logic        watch_sel,
  input logic [2:0]  mode,
  input logic        main_clk_en,
  input logic        sub_clk_en,
  input logic        stby,
  input logic        low_spd,
  input logic        settle_busy,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_rd_data
);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACTIVE && sleep_req && !settle_busy && !stby) |=> (mode == MODE_SLEEP)); // R4
  AST_SUBSLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SUBACT && sleep_req && !stby) |=> (mode == MODE_SUBSLEEP)); // R5
  AST_WATCH_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACTIVE && sleep_req && !settle_busy && stby && watch_sel) |=> (mode == MODE_WATCH)); // R6
  AST_STANDBY_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACTIVE && sleep_req && !settle_busy && stby && !watch_sel) |=> (mode == MODE_STANDBY)); // R6
  AST_WATCH_FROM_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SUBACT && sleep_req && stby) |=> (mode == MODE_WATCH)); // R7
  AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP && wake_evt) |=> (mode == MODE_ACTIVE)); // R8
  AST_WAKE_SUBSLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SUBSLEEP && wake_evt) |=> (mode == MODE_SUBACT)); // R8
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACTIVE && !sleep_req) |=> (mode == MODE_ACTIVE)); // R8
  AST_WATCH_TO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WATCH && wake_evt && low_spd) |=> (mode == MODE_SUBACT)); // R9
  AST_WATCH_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WATCH && wake_evt && !low_spd) |=> (mode == MODE_ACTIVE && !main_clk_en)); // R10
  AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !main_clk_en); // R10
  AST_STANDBY_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STANDBY) |-> (!main_clk_en && !sub_clk_en)); // R11
  AST_MAIN_EN_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    main_clk_en |-> (mode == MODE_ACTIVE || mode == MODE_SLEEP)); // R11
  AST_FIXED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'hFFF0) |-> bus_rd_data[2]); // R2

endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .wake_evt    (wake_evt),
  .watch_sel   (watch_sel),
  .mode        (mode_o),
  .main_clk_en (main_clk_en),
  .sub_clk_en  (sub_clk_en),
  .stby        (stby_w),
  .low_spd     (low_spd_w),
  .settle_busy (settle_busy_w),
  .bus_addr    (bus_addr),
  .bus_rd_data (bus_rd_data)
);

// File: tb/lpm_sequencer_bench.sv
`timescale 1ns/1ps
module lpm_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wr_data = 8'h00;
  logic [7:0]  bus_rd_data;
  logic        sleep_req = 1'b0;
  logic        wake_evt = 1'b0;
  logic        watch_sel = 1'b0;
  logic [2:0]  mode_o;
  logic        main_clk_en;
  logic        sub_clk_en;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lpm_sequencer u_lpm_sequencer (
    .clk, .rst_n, .bus_wr_en, .bus_addr, .bus_wr_data, .bus_rd_data,
    .sleep_req, .wake_evt, .watch_sel, .mode_o, .main_clk_en, .sub_clk_en
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    tick();
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk_eq(req, bus_rd_data, exp);
  endtask

  task automatic do_sleep();
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
  endtask

  task automatic do_wake();
    wake_evt = 1'b1; tick(); wake_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1 mode", mode_o, 0);
    chk_eq("R1 main_en", main_clk_en, 1);
    chk_eq("R1 sub_en", sub_clk_en, 1);
    rd_chk("R1 reg1", 16'hFFF0, 8'h07);
    rd_chk("R1 reg2", 16'hFFF1, 8'hF0);
  endtask

  task automatic t_regs();
    wr(16'hFFF0, 8'hF8);
    rd_chk("R2 reg1 bit2 forced", 16'hFFF0, 8'hFC);
    wr(16'hFFF0, 8'h00);
    rd_chk("R2 reg1 zero", 16'hFFF0, 8'h04);
    wr(16'hFFF2, 8'hFF);
    rd_chk("R2 unmapped write ignored", 16'hFFF0, 8'h04);
    wr(16'hFFF1, 8'h05);
    rd_chk("R3 reg2", 16'hFFF1, 8'hF5);
    wr(16'hFFF1, 8'h0A);
    rd_chk("R3 reg2 upper ones", 16'hFFF1, 8'hFA);
  endtask

  task automatic t_sleep();
    wr(16'hFFF0, 8'h00);
    do_sleep();
    chk_eq("R4 sleep mode", mode_o, 1);
    chk_eq("R11 main_en in sleep", main_clk_en, 1);
    chk_eq("R11 sub_en in sleep", sub_clk_en, 1);
    do_wake();
    chk_eq("R8 sleep to active", mode_o, 0);
    do_wake();
    chk_eq("R8 wake ignored in active", mode_o, 0);
  endtask

  task automatic t_standby();
    wr(16'hFFF0, 8'h80);
    watch_sel = 1'b0;
    do_sleep();
    chk_eq("R6 standby mode", mode_o, 2);
    chk_eq("R11 main_en standby", main_clk_en, 0);
    chk_eq("R11 sub_en standby", sub_clk_en, 0);
    do_wake();
    chk_eq("R10 active after standby", mode_o, 0);
    chk_eq("R10 main held", main_clk_en, 0);
    do_sleep();
    ticks(254);
    chk_eq("R10 sleep ignored in hold", mode_o, 0);
    chk_eq("R10 main held at 255", main_clk_en, 0);
    tick();
    chk_eq("R10 main released at 256", main_clk_en, 1);
  endtask

  task automatic t_watch_active();
    wr(16'hFFF0, 8'h90);
    watch_sel = 1'b1;
    do_sleep();
    chk_eq("R6 watch mode", mode_o, 3);
    chk_eq("R11 main_en watch", main_clk_en, 0);
    chk_eq("R11 sub_en watch", sub_clk_en, 1);
    do_wake();
    chk_eq("R9 watch to active", mode_o, 0);
    ticks(511);
    chk_eq("R10 main held at 511", main_clk_en, 0);
    tick();
    chk_eq("R10 main released at 512", main_clk_en, 1);
  endtask

  task automatic t_sub();
    wr(16'hFFF0, 8'h88);
    watch_sel = 1'b1;
    do_sleep();
    do_wake();
    chk_eq("R9 watch to subactive", mode_o, 4);
    chk_eq("R11 main_en subactive", main_clk_en, 0);
    chk_eq("R11 sub_en subactive", sub_clk_en, 1);
    do_wake();
    chk_eq("R8 wake ignored in subactive", mode_o, 4);
    wr(16'hFFF0, 8'h08);
    do_sleep();
    chk_eq("R5 subsleep mode", mode_o, 5);
    do_wake();
    chk_eq("R8 subsleep to subactive", mode_o, 4);
    wr(16'hFFF0, 8'h88);
    watch_sel = 1'b0;
    do_sleep();
    chk_eq("R7 watch from subactive", mode_o, 3);
  endtask

  initial begin
    ticks(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_sleep();
    t_standby();
    t_watch_active();
    t_sub();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule